// File: doc/BRIEF.md
# Micro-frame index counter with lagging SOF value

This block keeps the frame index of a high-speed USB host controller. The index is 14 bits wide. Its three low bits count micro-frames, and its upper eleven bits count host frames. A one-cycle micro-frame tick, qualified by a run input, advances the index by one. The host-frame field therefore steps once every eight micro-frames, when the micro-frame field wraps.

Next to the index sits an 11-bit start-of-frame value. This is the frame number that goes into SOF tokens on the bus. It steps when the micro-frame field moves from 0 to 1, not on the frame carry. As a result, bus frames trail host frames by exactly one micro-frame, and the number carried on the bus stays the same for eight consecutive SOFs.

Software can load the whole index at any time. The SOF value is then derived from the written value, so the lag holds from the first cycle. Reset clears the index. It sets the SOF value to the frame before frame 0, which keeps the lag rule true out of reset.

Top module: `uframe_index_ctr`

## Requirements
- R1: While reset is asserted and after its release, the index reads 0 and the SOF value reads 2047 (all ones) until a tick or a write changes them.
- R2: A qualified tick (tick_i and run_i both high, no write) increments the micro-frame field, index bits [2:0], by one on the next clock, wrapping from 7 to 0.
- R3: The host-frame field, index bits [13:3], increments only on a qualified tick that finds the micro-frame field at 7, and wraps from 2047 to 0 without any flag.
- R4: The SOF value increments only on a qualified tick that finds the micro-frame field at 0, which is the 0-to-1 step, and wraps from 2047 to 0.
- R5: At every clock the SOF value equals the host-frame field minus one (modulo 2048) when the micro-frame field is 0, and equals the host-frame field otherwise. It therefore holds one value across eight consecutive micro-frames.
- R6: With no write and no qualified tick, the index and the SOF value hold. A tick while run_i is low has no effect.
- R7: A write loads all 14 bits of wr_data_i into the index on the next clock. The SOF value becomes wr_data_i[13:3], minus one when wr_data_i[2:0] is 0.
- R8: A write that arrives in the same cycle as a qualified tick wins, and the tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle micro-frame tick |
| run_i | input | 1 | Run enable that qualifies the tick |
| wr_en_i | input | 1 | Software write strobe for the index |
| wr_data_i | input | 14 | Value written into the index |
| index_o | output | 14 | Current index: [13:3] host frame, [2:0] micro-frame |
| sof_o | output | 11 | Frame number for SOF tokens, one micro-frame behind |

## Verification
The properties assume that every input is a clean, synchronous level sampled on the rising edge. They also assume that a write strobe and its data are valid in the same cycle. Under those conditions the lag relation between the SOF value and the index must hold at every clock after reset.

The stimulus changes inputs only on falling edges. It keeps the tick one cycle wide, with runs of back-to-back ticks and ticks with gaps. It covers ticks with run low, writes alone, and writes that collide with a tick. Writes land just before the frame-field wrap and on micro-frame 0, so the wrap and the minus-one load are both reached.

// File: rtl/ufi_pkg.sv
package ufi_pkg;
  localparam int unsigned UF_W_DEF = 3;
  localparam int unsigned FR_W_DEF = 11;

  // SOF value implied by a frame field and a micro-frame field that is zero or not
  function automatic logic [FR_W_DEF-1:0] lag_frame(input logic [FR_W_DEF-1:0] frame,
                                                    input logic              uf_zero);
    lag_frame = frame - {{(FR_W_DEF-1){1'b0}}, uf_zero};
  endfunction
endpackage

// File: rtl/ufi_micro_cnt.sv
module ufi_micro_cnt #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         leave0_o
);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld_i | adv_i;
    cnt_d  = cnt_q;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (adv_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign wrap_o   = adv_i & ~ld_i & (cnt_q == MAX_VAL);
  assign leave0_o = adv_i & ~ld_i & (cnt_q == '0);
endmodule

// File: rtl/ufi_wrap_cnt.sv
module ufi_wrap_cnt #(
  parameter int unsigned    W       = 11,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld_i | inc_i;
    cnt_d  = cnt_q;
    if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/uframe_index_ctr.sv
module uframe_index_ctr #(
  parameter int unsigned UF_W = ufi_pkg::UF_W_DEF,
  parameter int unsigned FR_W = ufi_pkg::FR_W_DEF,
  localparam int unsigned IDX_W = UF_W + FR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_data_i,
  output logic [IDX_W-1:0] index_o,
  output logic [FR_W-1:0]  sof_o
);
  logic             adv;
  logic [UF_W-1:0]  uf_cnt;
  logic [FR_W-1:0]  fr_cnt;
  logic             uf_wrap;
  logic             uf_leave0;
  logic [UF_W-1:0]  wr_uf;
  logic [FR_W-1:0]  wr_fr;
  logic             wr_uf_zero;
  logic [FR_W-1:0]  wr_sof;

  // qualified micro-frame tick; a write overrides it inside each counter
  assign adv = tick_i & run_i;

  assign wr_uf      = wr_data_i[UF_W-1:0];
  assign wr_fr      = wr_data_i[IDX_W-1:UF_W];
  assign wr_uf_zero = (wr_uf == '0);
  assign wr_sof     = wr_fr - {{(FR_W-1){1'b0}}, wr_uf_zero};

  ufi_micro_cnt #(.W(UF_W)) i_uf (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv),
    .ld_i     (wr_en_i),
    .ld_val_i (wr_uf),
    .cnt_o    (uf_cnt),
    .wrap_o   (uf_wrap),
    .leave0_o (uf_leave0)
  );

  // host-frame field: steps on the micro-frame carry
  ufi_wrap_cnt #(.W(FR_W), .RST_VAL('0)) i_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (uf_wrap),
    .ld_i     (wr_en_i),
    .ld_val_i (wr_fr),
    .cnt_o    (fr_cnt)
  );

  // SOF shadow: steps on the 0-to-1 micro-frame step; resets to frame 0 minus one
  ufi_wrap_cnt #(.W(FR_W), .RST_VAL({FR_W{1'b1}})) i_sof (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (uf_leave0),
    .ld_i     (wr_en_i),
    .ld_val_i (wr_sof),
    .cnt_o    (sof_o)
  );

  assign index_o = {fr_cnt, uf_cnt};
endmodule

// File: rtl/ufi_checker.sv
module ufi_checker #(
  parameter int unsigned UF_W = 3,
  parameter int unsigned FR_W = 11,
  localparam int unsigned IDX_W = UF_W + FR_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             run_i,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_data_i,
  input logic [IDX_W-1:0] index_o,
  input logic [FR_W-1:0]  sof_o
);
  logic [UF_W-1:0] uf;
  logic [FR_W-1:0] fr;
  logic            qtick;

  assign uf    = index_o[UF_W-1:0];
  assign fr    = index_o[IDX_W-1:UF_W];
  assign qtick = tick_i & run_i & ~wr_en_i;

  AST_UF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> uf == UF_W'($past(uf) + 1'b1)); // R2

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (qtick && uf == {UF_W{1'b1}}) |=> fr == FR_W'($past(fr) + 1'b1)); // R3

  AST_FRAME_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !(qtick && uf == {UF_W{1'b1}})) |=> $stable(fr)); // R3

  AST_SOF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (qtick && uf == '0) |=> sof_o == FR_W'($past(sof_o) + 1'b1)); // R4

  AST_SOF_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o == FR_W'(fr - FR_W'(uf == '0))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !(tick_i && run_i)) |=> ($stable(index_o) && $stable(sof_o))); // R6

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> index_o == $past(wr_data_i)); // R7

  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && tick_i && run_i) |=> index_o == $past(wr_data_i)); // R8
endmodule

bind uframe_index_ctr ufi_checker #(.UF_W(UF_W), .FR_W(FR_W)) i_ufi_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .run_i     (run_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .index_o   (index_o),
  .sof_o     (sof_o)
);

// File: tb/test_uframe_index_ctr.sv
`timescale 1ns/1ps
module test_uframe_index_ctr;
  localparam int IDX_W = 14;
  localparam int FR_W  = 11;

  typedef struct {
    logic [IDX_W-1:0] idx;
    logic [FR_W-1:0]  sof;
    string            tag;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic             tick_i;
  logic             run_i;
  logic             wr_en_i;
  logic [IDX_W-1:0] wr_data_i;
  logic [IDX_W-1:0] index_o;
  logic [FR_W-1:0]  sof_o;

  int   n_checks;
  int   n_errors;
  exp_t sb_q[$];
  logic [IDX_W-1:0] m_idx;
  logic [FR_W-1:0]  m_sof;
  logic             done;

  uframe_index_ctr i_uframe_index_ctr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .index_o(index_o), .sof_o(sof_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [IDX_W-1:0] ai, input logic [FR_W-1:0] as,
                       input logic [IDX_W-1:0] ei, input logic [FR_W-1:0] es);
    n_checks++;
    if (ai !== ei || as !== es) begin
      n_errors++;
      $display("FAIL %s index=%h sof=%0d expected index=%h sof=%0d", tag, ai, as, ei, es);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic drive(input logic tk, input logic rn, input logic wr,
                       input logic [IDX_W-1:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    tick_i = tk; run_i = rn; wr_en_i = wr; wr_data_i = d;
    if (wr) begin
      m_idx = d;
      m_sof = d[IDX_W-1:3] - ((d[2:0] == 3'd0) ? 11'd1 : 11'd0);
    end else if (tk && rn) begin
      if (m_idx[2:0] == 3'd0) m_sof = m_sof + 11'd1;
      m_idx = m_idx + 14'd1;
    end
    e.idx = m_idx; e.sof = m_sof; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares one expected item per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, index_o, sof_o, e.idx, e.sof);
      // R5 lag relation checked on the outputs themselves
      check("R5", index_o, sof_o, index_o,
            index_o[IDX_W-1:3] - ((index_o[2:0] == 3'd0) ? 11'd1 : 11'd0));
    end
  end

  initial begin
    #(200000 * 4);
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    tick_i = 0; run_i = 0; wr_en_i = 0; wr_data_i = '0;
    rst_n = 1'b0;
    m_idx = '0; m_sof = 11'h7FF;
    repeat (3) @(negedge clk);
    check("R1", index_o, sof_o, 14'd0, 11'd2047);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", index_o, sof_o, 14'd0, 11'd2047);

    // back-to-back ticks across several frames
    for (int i = 0; i < 25; i++) drive(1, 1, 0, '0, "R2");
    // ticks with run low, then idle cycles
    for (int i = 0; i < 4; i++) drive(1, 0, 0, '0, "R6");
    for (int i = 0; i < 3; i++) drive(0, 1, 0, '0, "R6");
    // spaced ticks
    for (int i = 0; i < 10; i++) begin
      drive(1, 1, 0, '0, "R4");
      drive(0, 1, 0, '0, "R6");
    end
    // load near the frame-field wrap, then run across it
    drive(0, 0, 1, {11'd2047, 3'd5}, "R7");
    for (int i = 0; i < 20; i++) drive(1, 1, 0, '0, "R3");
    // load with micro-frame 0: SOF value is frame minus one
    drive(0, 1, 1, {11'd100, 3'd0}, "R7");
    drive(1, 1, 0, '0, "R4");
    drive(0, 1, 1, {11'd0, 3'd0}, "R7");
    drive(0, 1, 0, '0, "R6");
    drive(1, 1, 0, '0, "R4");
    // write colliding with a qualified tick
    drive(1, 1, 1, {11'd555, 3'd7}, "R8");
    drive(1, 1, 1, {11'd9, 3'd0}, "R8");
    drive(1, 1, 1, {11'd9, 3'd0}, "R8");
    for (int i = 0; i < 9; i++) drive(1, 1, 0, '0, "R2");
    // write while run is low
    drive(1, 0, 1, {11'd1234, 3'd3}, "R7");
    drive(1, 0, 0, '0, "R6");
    drive(0, 0, 0, '0, "R6");
    drive(0, 0, 0, '0, "R6");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule